// File: doc/BRIEF.md
# GPIO Port with Event Capture Interrupt

A bus-attached general purpose I/O port with up to 32 pins. Software sets the level and the direction of each pin through a small word-addressed register file. The pin inputs are brought into the clock domain through a synchroniser before anything reads them. A trigger mode fixed when the block is built decides what raises the interrupt: a rising transition, a falling transition, either transition, or a high input level.

In the three edge modes every detected transition sets a sticky bit in an event register. Software clears that register by writing ones to it. The interrupt line is high while any sticky bit has its enable bit set. In level mode the event register stays empty, and the interrupt follows the enabled, synchronised pin levels directly. One block instance drives one interrupt line.

Top module: `gpio_edge_irq`

## Requirements
- R1: After a synchronous reset every register reads zero, `pin_oe` and `pin_out` are zero, and `irq` is low.
- R2: Word index 0 is pin data, 1 is direction, 2 is interrupt enable, 3 is event capture (byte offsets 0x0, 0x4, 0x8, 0xC). `rdata` holds the addressed value from the cycle after `rd_en` and keeps it until the next read. Direction and enable read back the last value written.
- R3: A write to direction appears on `pin_oe` after the write edge (1 = output). A write to data appears on `pin_out`.
- R4: A read of data returns the synchronised pin levels, two clock edges behind `pin_in`, and not the output register.
- R5: In rising mode a 0-to-1 transition of a pin sets its capture bit and a 1-to-0 transition does not.
- R6: In falling mode a 1-to-0 transition of a pin sets its capture bit and a 0-to-1 transition does not.
- R7: In both-edges mode any transition of a pin sets its capture bit.
- R8: In level mode the capture register stays zero, and `irq` is high while the synchronised pins AND the enable register is nonzero.
- R9: A write to capture clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R10: A transition detected on the same edge as a clear of that pin leaves its capture bit set.
- R11: In edge modes `irq` is high exactly while capture AND enable is nonzero, so an enable of zero keeps `irq` low.
- R12: Register bits at and above the pin count read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 2 | Word index of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| pin_in | input | NPINS | Pin input levels (asynchronous) |
| pin_out | output | NPINS | Pin output levels |
| pin_oe | output | NPINS | Pin output enables, 1 = drive |
| irq | output | 1 | Combined interrupt |

## Verification
A stuck or lost capture bit shows at `irq` on the first edge after the transition has passed the synchroniser, three edges after the pin moves, and at `rdata` one cycle after the next read of the capture word. A wrong trigger decode shows up as a capture pattern that differs from the XOR, AND-NOT or NOT-AND of the old and new pin vectors. The bench compares these patterns over a sweep of vector pairs on four instances, one for each mode. A wrong set-versus-clear priority is visible only when a clear write lands on the exact edge where the event registers, so that collision is driven cycle-accurately.

// File: rtl/gpio_irq_pkg.sv
// Shared definitions for the GPIO event-capture port.
// Assumes: register selection by a 2-bit word index.
package gpio_irq_pkg;
    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_mode_e;

    localparam int unsigned REG_AW = 2;
    localparam logic [REG_AW-1:0] REG_DATA = 2'd0;
    localparam logic [REG_AW-1:0] REG_DIR  = 2'd1;
    localparam logic [REG_AW-1:0] REG_MASK = 2'd2;
    localparam logic [REG_AW-1:0] REG_CAP  = 2'd3;
endpackage

// File: rtl/gpio_pin_sync.sv
// Two-flop synchroniser followed by one history flop for each pin.
// Assumes: pin inputs are asynchronous; the synchroniser resets to 0,
// so the pins should be low when reset is released.
module gpio_pin_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q, lvl_q, prev_q;

    // Purpose: resynchronise the pins and keep last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw_i;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign lvl_o  = lvl_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/gpio_edge_detect.sv
// Turns the current and previous synchronised levels into one-cycle
// event pulses, following the trigger mode fixed when the block is built.
// Assumes: in level mode no events are produced.
module gpio_edge_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W    = 32,
    parameter trig_mode_e  TRIG = TRIG_BOTH
) (
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] prev_i,
    output logic [W-1:0] evt_o
);
    generate
        if (TRIG == TRIG_RISE) begin : g_rise
            // Purpose: low-to-high transitions.
            always_comb evt_o = lvl_i & ~prev_i;
        end else if (TRIG == TRIG_FALL) begin : g_fall
            // Purpose: high-to-low transitions.
            always_comb evt_o = ~lvl_i & prev_i;
        end else if (TRIG == TRIG_BOTH) begin : g_both
            // Purpose: any transition.
            always_comb evt_o = lvl_i ^ prev_i;
        end else begin : g_level
            // Purpose: level mode needs no events.
            always_comb evt_o = '0;
        end
    endgenerate
endmodule

// File: rtl/gpio_capture.sv
// Sticky event register, cleared by writing ones. On the same edge a
// new event wins over a clear of that bit.
// Assumes: clr_i is nonzero only in the cycle of a capture write.
module gpio_capture #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] cap_o
);
    logic [W-1:0] cap_q;

    // Purpose: clear the requested bits, then OR in the new events.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= (cap_q & ~clr_i) | evt_i;
    end

    assign cap_o = cap_q;

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((cap_q & $past(evt_i)) == $past(evt_i))); // R10
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~evt_i) != '0) |=> ((cap_q & $past(clr_i & ~evt_i)) == '0)); // R9
    AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0 && evt_i == '0) |=> $stable(cap_q)); // R9
endmodule

// File: rtl/gpio_edge_irq.sv
// GPIO port with registers for output data, direction, interrupt enable
// and event capture, and one combined interrupt output.
// Assumes: NPINS <= DATA_W <= 32; addr is a word index; rdata is
// registered and is valid from the cycle after rd_en.
module gpio_edge_irq
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned DATA_W = 32,
    parameter trig_mode_e  TRIG   = TRIG_BOTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    localparam bit LEVEL_MODE = (TRIG == TRIG_LEVEL);

    logic [NPINS-1:0]  out_q, dir_q, mask_q;
    logic [NPINS-1:0]  lvl, prev, evt, clr, cap;
    logic [DATA_W-1:0] rd_word, rdata_q;
    logic [NPINS-1:0]  irq_src;

    gpio_pin_sync #(.W(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_in),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    gpio_edge_detect #(.W(NPINS), .TRIG(TRIG)) u_detect (
        .lvl_i  (lvl),
        .prev_i (prev),
        .evt_o  (evt)
    );

    // Purpose: clear mask, nonzero only while the capture word is written.
    always_comb clr = (wr_en && addr == REG_CAP) ? wdata[NPINS-1:0] : '0;

    gpio_capture #(.W(NPINS)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt),
        .clr_i (clr),
        .cap_o (cap)
    );

    // Purpose: writable control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            case (addr)
                REG_DATA: out_q  <= wdata[NPINS-1:0];
                REG_DIR:  dir_q  <= wdata[NPINS-1:0];
                REG_MASK: mask_q <= wdata[NPINS-1:0];
                default:  ;
            endcase
        end
    end

    // Purpose: select the addressed word, zero-extended above the pins.
    always_comb begin
        rd_word = '0;
        case (addr)
            REG_DATA: rd_word[NPINS-1:0] = lvl;
            REG_DIR:  rd_word[NPINS-1:0] = dir_q;
            REG_MASK: rd_word[NPINS-1:0] = mask_q;
            default:  rd_word[NPINS-1:0] = cap;
        endcase
    end

    // Purpose: register read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_word;
    end

    generate
        if (LEVEL_MODE) begin : g_irq_level
            // Purpose: interrupt source is the enabled pin level.
            always_comb irq_src = lvl & mask_q;
            AST_LEVEL_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
                cap == '0); // R8
        end else begin : g_irq_edge
            // Purpose: interrupt source is the enabled captured events.
            always_comb irq_src = cap & mask_q;
        end
        if (NPINS < DATA_W) begin : g_upper
            AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                rdata[DATA_W-1:NPINS] == '0); // R12
        end
    endgenerate

    assign irq     = |irq_src;
    assign rdata   = rdata_q;
    assign pin_out = out_q;
    assign pin_oe  = dir_q;

    AST_OE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_DIR) |=> (pin_oe == $past(wdata[NPINS-1:0]))); // R3
    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R2
endmodule

// File: tb/gpio_edge_irq_tb.sv
`timescale 1ns/1ps
module gpio_edge_irq_tb;
    import gpio_irq_pkg::*;

    localparam int NP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [NP-1:0] pins = '0;

    logic [31:0]   rd_b, rd_r, rd_f, rd_l;
    logic [NP-1:0] po_b, po_r, po_f, po_l;
    logic [NP-1:0] oe_b, oe_r, oe_f, oe_l;
    logic          irq_b, irq_r, irq_f, irq_l;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_edge_irq #(.NPINS(NP), .DATA_W(32), .TRIG(TRIG_BOTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rd_b), .pin_in(pins), .pin_out(po_b),
        .pin_oe(oe_b), .irq(irq_b));
    gpio_edge_irq #(.NPINS(NP), .DATA_W(32), .TRIG(TRIG_RISE)) u_rise (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rd_r), .pin_in(pins), .pin_out(po_r),
        .pin_oe(oe_r), .irq(irq_r));
    gpio_edge_irq #(.NPINS(NP), .DATA_W(32), .TRIG(TRIG_FALL)) u_fall (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rd_f), .pin_in(pins), .pin_out(po_f),
        .pin_oe(oe_f), .irq(irq_f));
    gpio_edge_irq #(.NPINS(NP), .DATA_W(32), .TRIG(TRIG_LEVEL)) u_lvl (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rd_l), .pin_in(pins), .pin_out(po_l),
        .pin_oe(oe_l), .irq(irq_l));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 oe", {24'd0, oe_b}, 32'd0);
        chk("R1 out", {24'd0, po_b}, 32'd0);
        chk("R1 irq", {31'd0, irq_b}, 32'd0);
        for (int a = 0; a < 4; a++) begin
            bus_rd(a[1:0]);
            chk("R1 reg", rd_b, 32'd0);
        end

        // R3, R2, R12: direction and data registers
        bus_wr(REG_DIR, 32'h0000_003C);
        chk("R3 oe", {24'd0, oe_b}, 32'h3C);
        bus_wr(REG_DATA, 32'h0000_005A);
        chk("R3 out", {24'd0, po_b}, 32'h5A);
        bus_rd(REG_DIR);
        chk("R2 dir readback", rd_b, 32'h3C);
        bus_wr(REG_MASK, 32'hFFFF_FFFF);
        bus_rd(REG_MASK);
        chk("R12 mask upper zero", rd_b, 32'h0000_00FF);

        // R4: data read returns pins two edges later, not output register
        @(negedge clk); pins = 8'h81;
        @(negedge clk);
        bus_rd(REG_DATA);
        chk("R4 data read", rd_b, 32'h81);
        @(negedge clk); pins = 8'h00;
        repeat (4) @(negedge clk);
        bus_wr(REG_CAP, 32'hFFFF_FFFF);

        // R5 R6 R7 R8 R11: sweep of transitions
        for (int i = 0; i < 24; i++) begin
            logic [7:0] pv, nv, mk, eb, er, ef;
            pv = 8'((i * 37 + 5) & 255);
            nv = 8'((i * 91 + 13) & 255);
            mk = 8'((i * 53 + 3) & 255);
            if (i == 5) mk = 8'h00;
            eb = pv ^ nv;
            er = ~pv & nv;
            ef = pv & ~nv;
            bus_wr(REG_MASK, {24'd0, mk});
            @(negedge clk); pins = pv;
            repeat (4) @(negedge clk);
            bus_wr(REG_CAP, 32'hFFFF_FFFF);
            pins = nv;
            repeat (4) @(negedge clk);
            chk("R11 irq both", {31'd0, irq_b}, {31'd0, |(eb & mk)});
            chk("R11 irq rise", {31'd0, irq_r}, {31'd0, |(er & mk)});
            chk("R11 irq fall", {31'd0, irq_f}, {31'd0, |(ef & mk)});
            chk("R8 irq level", {31'd0, irq_l}, {31'd0, |(nv & mk)});
            bus_rd(REG_CAP);
            chk("R7 cap both", rd_b, {24'd0, eb});
            chk("R5 cap rise", rd_r, {24'd0, er});
            chk("R6 cap fall", rd_f, {24'd0, ef});
            chk("R8 cap level", rd_l, 32'd0);
            bus_rd(REG_DATA);
            chk("R4 data sweep", rd_b, {24'd0, nv});
        end

        // R9: partial clear and zero write
        @(negedge clk); pins = 8'h00;
        repeat (4) @(negedge clk);
        bus_wr(REG_CAP, 32'hFFFF_FFFF);
        pins = 8'hFF;
        repeat (4) @(negedge clk);
        bus_wr(REG_CAP, 32'h0000_000F);
        bus_rd(REG_CAP);
        chk("R9 partial clear", rd_r, 32'hF0);
        bus_wr(REG_CAP, 32'h0000_0000);
        bus_rd(REG_CAP);
        chk("R9 zero write keeps", rd_r, 32'hF0);
        bus_wr(REG_MASK, 32'd0);
        chk("R11 mask zero", {31'd0, irq_r}, 32'd0);

        // R10: event and clear on the same edge
        @(negedge clk); pins = 8'h00;
        repeat (4) @(negedge clk);
        bus_wr(REG_CAP, 32'hFFFF_FFFF);
        pins = 8'h01;
        @(posedge clk);
        @(posedge clk);
        bus_wr(REG_CAP, 32'hFFFF_FFFF);
        bus_rd(REG_CAP);
        chk("R10 set wins both", rd_b, 32'h01);
        chk("R10 set wins rise", rd_r, 32'h01);
        chk("R10 fall untouched", rd_f, 32'h00);
        bus_wr(REG_CAP, 32'h0000_0001);
        bus_rd(REG_CAP);
        chk("R9 later clear", rd_b, 32'h00);

        finish_run();
    end
endmodule